// File: doc/BRIEF.md
# Isochronous Receive Burst Checker

This block watches the data packets that a USB host takes in on one isochronous IN endpoint during each microframe. The number of packets in a microframe varies with how much data the device sends. The data PID of the first packet tells how many packets make up the burst. Each packet after the first must carry the next lower data PID. The burst ends when DATA0 arrives.

Two faults are reported through sticky status flags. The first is a microframe that ends while a burst is still open. The second is a packet whose data PID is not the one expected next. In both cases the endpoint interrupt still fires, so software can drain the partial data from the FIFO. A burst that completes normally also raises the interrupt. A clear strobe resets the flags. Token generation, CRC checking and FIFO storage are handled elsewhere.

Top module: `iso_rx_burst_check`

## Requirements
- R1: While `rst_n` is low at a clock edge, both status flags and `ep_irq` are 0 after that edge, and any open burst is forgotten.
- R2: PID codes on `pkt_pid` are 0 = DATA0, 1 = DATA1, 2 = DATA2, and 3 = reserved. The first packet of a microframe sets the burst length: DATA2 gives three packets, DATA1 gives two and DATA0 gives one.
- R3: Within a burst, each later packet must carry the PID one below the previous one. Receiving the expected DATA0 completes the burst, which pulses `ep_irq` without setting any flag.
- R4: If a burst is still open when `uframe_start` is sampled high, `incomplete_flag` is set and `ep_irq` pulses.
- R5: A packet that carries the wrong PID for its position, or the reserved code 3, sets `pid_err_flag` and pulses `ep_irq`. It also closes the burst, so the next `uframe_start` does not flag an incomplete burst.
- R6: A packet that arrives after the burst has completed in the same microframe sets `pid_err_flag` and pulses `ep_irq`.
- R7: Both flags stay set until `status_clr` is sampled high. If a flag's set event and `status_clr` occur in the same cycle, that flag ends up set.
- R8: When `uframe_start` and `pkt_valid` are high in the same cycle, the old microframe is closed first (with its incomplete check), and the packet is then taken as the first packet of the new microframe.
- R9: `ep_irq` is high for exactly the one cycle after a cycle that had a completion, incomplete or PID-error event, and low otherwise. A `uframe_start` with no open burst causes no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uframe_start | input | 1 | One-cycle strobe: a microframe begins and the previous one ends |
| pkt_valid | input | 1 | One-cycle strobe: a data packet was received |
| pkt_pid | input | 2 | Decoded data PID of that packet (0 DATA0, 1 DATA1, 2 DATA2, 3 reserved) |
| status_clr | input | 1 | Clears both status flags |
| incomplete_flag | output | 1 | Sticky: a microframe ended with a burst still open |
| pid_err_flag | output | 1 | Sticky: an unexpected data PID was seen |
| ep_irq | output | 1 | One-cycle endpoint interrupt pulse |

## Verification
The bench targets a microframe strobe that arrives in the same cycle as a packet. A design that takes the packet before closing the frame would either miss the incomplete flag or reject a valid first packet. It sends packets after a completed burst and a DATA2 burst that skips DATA1. A design that idles after completion, or that checks only for DATA0 at the end, would accept these silently. It also ends a microframe after a PID error. A design that leaves the burst open would raise a false incomplete flag there. Finally, it makes a clear and a new error collide in the same cycle. A design that gives priority to the clear would lose the error.

// File: rtl/iso_rx_pkg.sv
// Package iso_rx_pkg
// Shared encodings for the isochronous receive burst checker.
// Assumes data PIDs arrive already decoded into a small rank code.
package iso_rx_pkg;

    // Burst tracking phase within one microframe
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,  // no packet seen yet in this microframe
        PH_OPEN   = 2'd1,  // burst started, more packets expected
        PH_CLOSED = 2'd2   // burst completed or aborted by an error
    } phase_e;

    // Index of each event in the event vector
    localparam int EV_INCOMPLETE = 0;
    localparam int EV_PID_ERR    = 1;
    localparam int EV_DONE       = 2;
    localparam int N_EVENTS      = 3;

    // Number of sticky status flags (incomplete, pid error)
    localparam int N_FLAGS = 2;

endpackage

// File: rtl/iso_rx_seq_tracker.sv
// Module iso_rx_seq_tracker
// Follows the data PID sequence of one microframe and reports events
// combinationally: burst completion, PID error, and an incomplete burst
// at the end of a microframe.
// Assumes: pkt_pid holds the rank code (0 = lowest data PID), codes
// above TOP_RANK are reserved, and the strobes last one cycle each.
module iso_rx_seq_tracker
    import iso_rx_pkg::*;
#(
    parameter int PID_W    = 2,
    parameter int TOP_RANK = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                uframe_start,
    input  logic                pkt_valid,
    input  logic [PID_W-1:0]    pkt_pid,
    output logic [N_EVENTS-1:0] events
);

    localparam logic [PID_W-1:0] TOP_CODE  = PID_W'(TOP_RANK);
    localparam logic [PID_W-1:0] LAST_CODE = '0;
    localparam logic [PID_W-1:0] ONE_CODE  = PID_W'(1);

    phase_e           phase_q, phase_d, phase_eff;
    logic [PID_W-1:0] exp_q, exp_d;

    // Next-state and event logic: close the old frame first, then take the packet
    always_comb begin
        phase_eff = uframe_start ? PH_IDLE : phase_q;
        phase_d   = phase_eff;
        exp_d     = exp_q;
        events    = '0;
        events[EV_INCOMPLETE] = uframe_start && (phase_q == PH_OPEN);
        if (pkt_valid) begin
            unique case (phase_eff)
                PH_IDLE: begin
                    if (pkt_pid > TOP_CODE) begin
                        events[EV_PID_ERR] = 1'b1;
                        phase_d            = PH_CLOSED;
                    end else if (pkt_pid == LAST_CODE) begin
                        events[EV_DONE] = 1'b1;
                        phase_d         = PH_CLOSED;
                    end else begin
                        phase_d = PH_OPEN;
                        exp_d   = pkt_pid - ONE_CODE;
                    end
                end
                PH_OPEN: begin
                    if (pkt_pid != exp_q) begin
                        events[EV_PID_ERR] = 1'b1;
                        phase_d            = PH_CLOSED;
                    end else if (exp_q == LAST_CODE) begin
                        events[EV_DONE] = 1'b1;
                        phase_d         = PH_CLOSED;
                    end else begin
                        exp_d = exp_q - ONE_CODE;
                    end
                end
                default: begin
                    events[EV_PID_ERR] = 1'b1;
                    phase_d            = PH_CLOSED;
                end
            endcase
        end
    end

    // State registers for phase and next expected PID rank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            exp_q   <= '0;
        end else begin
            phase_q <= phase_d;
            exp_q   <= exp_d;
        end
    end

endmodule

// File: rtl/iso_rx_sticky_status.sv
// Module iso_rx_sticky_status
// A bank of sticky status bits. A set event wins over a clear in the
// same cycle, so no event is lost.
// Assumes set and clr are synchronous to clk.
module iso_rx_sticky_status #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] flags
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        // Hold one status bit: set wins, then clear, else keep
        always_ff @(posedge clk) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr)    flags[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/iso_rx_irq_pulse.sv
// Module iso_rx_irq_pulse
// Turns any event in a cycle into a one-cycle registered interrupt pulse.
// Assumes events are single-cycle combinational indications.
module iso_rx_irq_pulse #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] events,
    output logic         irq
);

    // Register the OR of all events as the interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |events;
    end

endmodule

// File: rtl/iso_rx_burst_check.sv
// Module iso_rx_burst_check (top)
// Checks the per-microframe packet burst on one isochronous IN endpoint.
// Flags incomplete bursts and unexpected data PIDs, and interrupts on
// completion and on each fault.
// Assumes one packet strobe per cycle at most and a decoded PID rank.
module iso_rx_burst_check
    import iso_rx_pkg::*;
#(
    parameter int PID_W    = 2,
    parameter int TOP_RANK = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uframe_start,
    input  logic             pkt_valid,
    input  logic [PID_W-1:0] pkt_pid,
    input  logic             status_clr,
    output logic             incomplete_flag,
    output logic             pid_err_flag,
    output logic             ep_irq
);

    logic [N_EVENTS-1:0] events;
    logic [N_FLAGS-1:0]  flag_set;
    logic [N_FLAGS-1:0]  flag_q;

    iso_rx_seq_tracker #(
        .PID_W    (PID_W),
        .TOP_RANK (TOP_RANK)
    ) u_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .uframe_start (uframe_start),
        .pkt_valid    (pkt_valid),
        .pkt_pid      (pkt_pid),
        .events       (events)
    );

    assign flag_set[0] = events[EV_INCOMPLETE];
    assign flag_set[1] = events[EV_PID_ERR];

    iso_rx_sticky_status #(
        .N (N_FLAGS)
    ) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (status_clr),
        .flags (flag_q)
    );

    iso_rx_irq_pulse #(
        .N (N_EVENTS)
    ) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .events (events),
        .irq    (ep_irq)
    );

    assign incomplete_flag = flag_q[0];
    assign pid_err_flag    = flag_q[1];

endmodule

// File: rtl/iso_rx_burst_check_sva.sv
// Module iso_rx_burst_check_sva
// Property checker for iso_rx_burst_check, attached with bind below.
module iso_rx_burst_check_sva (
    input logic clk,
    input logic rst_n,
    input logic uframe_start,
    input logic pkt_valid,
    input logic status_clr,
    input logic incomplete_flag,
    input logic pid_err_flag,
    input logic ep_irq
);

    // R4: the incomplete flag rises only after a microframe strobe, together with the interrupt
    a_r4_incomplete_from_uframe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(incomplete_flag) |-> ($past(uframe_start) && ep_irq));

    // R5: the PID error flag rises only after a packet, together with the interrupt
    a_r5_pid_err_from_packet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pid_err_flag) |-> ($past(pkt_valid) && ep_irq));

    // R7: flags stay set while no clear was sampled
    a_r7_incomplete_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (incomplete_flag && !status_clr) |=> incomplete_flag);

    a_r7_pid_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pid_err_flag && !status_clr) |=> pid_err_flag);

    // R7: a clear with no new event leaves both flags low
    a_r7_clear_effect: assert property (@(posedge clk) disable iff (!rst_n)
        status_clr |=> (ep_irq || (!incomplete_flag && !pid_err_flag)));

    // R9: no strobe, no interrupt in the next cycle
    a_r9_irq_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_valid && !uframe_start) |=> !ep_irq);

endmodule

bind iso_rx_burst_check iso_rx_burst_check_sva u_sva (.*);

// File: tb/iso_rx_burst_check_tb.sv
module iso_rx_burst_check_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 27;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       uframe_start = 1'b0;
    logic       pkt_valid = 1'b0;
    logic [1:0] pkt_pid = 2'd0;
    logic       status_clr = 1'b0;
    logic       incomplete_flag, pid_err_flag, ep_irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iso_rx_burst_check u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .uframe_start    (uframe_start),
        .pkt_valid       (pkt_valid),
        .pkt_pid         (pkt_pid),
        .status_clr      (status_clr),
        .incomplete_flag (incomplete_flag),
        .pid_err_flag    (pid_err_flag),
        .ep_irq          (ep_irq)
    );

    // Vector: {req[3:0], uf, pv, pid[1:0], clr, exp_inc, exp_err, exp_irq}
    // Expected values are the outputs one clock after the inputs are applied.
    localparam logic [11:0] VEC [N_VEC] = '{
        {4'd9, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 frame start, nothing open
        {4'd3, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 single DATA0 burst
        {4'd9, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 pulse drops
        {4'd9, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 closed burst, no event
        {4'd2, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 DATA2 opens 3-packet burst
        {4'd3, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 DATA1 expected
        {4'd3, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 DATA0 completes
        {4'd6, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1}, // R6 extra packet
        {4'd7, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 clear
        {4'd9, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 closed, no event
        {4'd2, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 DATA1 opens 2-packet burst
        {4'd4, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1}, // R4 frame ends early
        {4'd7, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0}, // R7 flag sticks
        {4'd2, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 new burst DATA1
        {4'd5, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1}, // R5 DATA1 where DATA0 due
        {4'd5, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0}, // R5 error closed burst
        {4'd7, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 clear both
        {4'd5, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1}, // R5 reserved code
        {4'd7, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 clear with quiet frame start
        {4'd2, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 DATA2 opens burst
        {4'd8, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1}, // R8 close old, DATA0 new
        {4'd6, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1}, // R6 packet after completion
        {4'd7, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1}, // R7 set wins over clear
        {4'd7, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 clear
        {4'd8, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 quiet close, DATA2 opens
        {4'd5, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1}, // R5 DATA0 skips DATA1
        {4'd7, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0}  // R7 clear
    };

    task automatic check(input int req, input logic ei, input logic ee, input logic eq);
        checks++;
        if (incomplete_flag !== ei || pid_err_flag !== ee || ep_irq !== eq) begin
            errors++;
            $display("FAIL R%0d: inc/err/irq actual %b%b%b expected %b%b%b",
                     req, incomplete_flag, pid_err_flag, ep_irq, ei, ee, eq);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check(1, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;

        // Vector table walk: drive at negedge, check at following negedge
        for (int i = 0; i < N_VEC; i++) begin
            uframe_start = VEC[i][7];
            pkt_valid    = VEC[i][6];
            pkt_pid      = VEC[i][5:4];
            status_clr   = VEC[i][3];
            @(negedge clk);
            check(int'(VEC[i][11:8]), VEC[i][2], VEC[i][1], VEC[i][0]);
        end
        uframe_start = 1'b0; pkt_valid = 1'b0; status_clr = 1'b0;

        // R1: reset with set flags and an open burst
        pkt_valid = 1'b1; pkt_pid = 2'd3;
        @(negedge clk);
        pkt_pid = 2'd2;          // opens a burst? no: burst already closed by error
        @(negedge clk);
        pkt_valid = 1'b0;
        uframe_start = 1'b1;
        @(negedge clk);
        uframe_start = 1'b0;
        pkt_valid = 1'b1; pkt_pid = 2'd2;   // open DATA2 burst in new frame
        @(negedge clk);
        pkt_valid = 1'b0;
        check(5, 1'b0, 1'b1, 1'b0);          // R5 flag from reserved code still held
        rst_n = 1'b0;
        @(negedge clk);
        check(1, 1'b0, 1'b0, 1'b0);          // R1 flags cleared by reset
        rst_n = 1'b1;
        uframe_start = 1'b1;
        @(negedge clk);
        uframe_start = 1'b0;
        check(1, 1'b0, 1'b0, 1'b0);          // R1 open burst forgotten: no incomplete

        // R2/R4: DATA2 burst cut after two packets
        pkt_valid = 1'b1; pkt_pid = 2'd2;
        @(negedge clk);
        pkt_pid = 2'd1;
        @(negedge clk);
        pkt_valid = 1'b0; uframe_start = 1'b1;
        @(negedge clk);
        uframe_start = 1'b0;
        check(4, 1'b1, 1'b0, 1'b1);          // R4 short DATA2 burst
        @(negedge clk);
        check(9, 1'b1, 1'b0, 1'b0);          // R9 single-cycle pulse

        finish_run();
    end

endmodule